// File: doc/BRIEF.md
# Ternary 5-Tuple Match Table

This block classifies packets by comparing a 104-bit flow key against a small table of stored entries, all at once. Software or a control path loads entries through a write port: each write names a slot, a stored key, a per-bit care mask and a valid flag. A lookup presents a key. Every valid entry compares against it in parallel, and any bit whose mask is clear matches whatever the key holds there. One clock later the block returns three results: whether anything hit, the index of the winning entry, and a bitmap of every entry that hit.

The key is packed with the most significant field first: a 32-bit source address, a 32-bit destination address, a 16-bit source port, a 16-bit destination port, and an 8-bit protocol. The table is built only from flip-flops and comparators. When several entries match the same key, the lowest-numbered one wins, so entries that need higher precedence go in lower slots. Parsing packets into keys and acting on the result are handled elsewhere.

The block has no control state machine. Its only sequencing is the write-then-compare order inside each slot and the single result register stage.

Top module: `tcam_filter`

## Requirements
- R1: After reset, every entry is invalid and `res_valid`, `hit`, `hit_idx` and `hit_map` are all zero.
- R2: A write with `wr_en` high and `wr_idx` below the entry count stores `wr_key`, `wr_mask` and `wr_valid` into that slot. A lookup made in any later cycle sees the new contents.
- R3: A mask bit of 1 makes the key bit at that position take part in the compare, and a mask bit of 0 makes it a don't-care. An entry matches when every cared bit of the lookup key equals its stored bit.
- R4: An entry whose valid flag is 0 never matches, whatever its key and mask hold.
- R5: A key presented with `lk_valid` high returns its results on the next clock, with `res_valid` high and bit i of `hit_map` set exactly when entry i matches. A cycle with `lk_valid` low returns `res_valid`, `hit` and `hit_map` all zero on the next clock.
- R6: `hit` is 1 when any entry matches. `hit_idx` is then the lowest matching index, and it is 0 when nothing matches.
- R7: A lookup in the same cycle as a write to a slot compares against the contents the slot held before that write.
- R8: A write whose `wr_idx` is not below the entry count (10) changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the table |
| wr_idx | input | 4 | Slot to write |
| wr_key | input | 104 | Key to store |
| wr_mask | input | 104 | Care mask, 1 = compare this bit |
| wr_valid | input | 1 | Valid flag to store |
| lk_valid | input | 1 | Lookup strobe |
| lk_key | input | 104 | Key to look up |
| res_valid | output | 1 | Lookup result present |
| hit | output | 1 | At least one entry matched |
| hit_idx | output | 4 | Lowest matching entry |
| hit_map | output | 10 | One bit per matching entry |

## Verification
A slot holding a wrong key, mask or valid bit shows up in `hit_map` on the clock after the first lookup that touches the affected bits. A miss turns into a hit, or a hit into a miss. Through the priority choice, the fault can also move `hit_idx`. Directed lookups therefore target single cared bits, wildcard fields, overlapping entries, invalidated entries and writes to out-of-range slots. Random lookups made close to stored keys then exercise many partial matches against an independent table model.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    localparam int SRC_ADDR_W = 32;
    localparam int DST_ADDR_W = 32;
    localparam int SRC_PORT_W = 16;
    localparam int DST_PORT_W = 16;
    localparam int PROTO_W    = 8;
    localparam int TUPLE_W    = SRC_ADDR_W + DST_ADDR_W + SRC_PORT_W + DST_PORT_W + PROTO_W;

    // Key layout, most significant field first.
    typedef struct packed {
        logic [SRC_ADDR_W-1:0] src_addr;
        logic [DST_ADDR_W-1:0] dst_addr;
        logic [SRC_PORT_W-1:0] src_port;
        logic [DST_PORT_W-1:0] dst_port;
        logic [PROTO_W-1:0]    proto;
    } flow_key_t;
endpackage

// File: rtl/tcam_slot.sv
module tcam_slot #(
    parameter int KEY_W = tcam_pkg::TUPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] ld_key,
    input  logic [KEY_W-1:0] ld_mask,
    input  logic             ld_valid,
    input  logic [KEY_W-1:0] probe_key,
    output logic             slot_valid,
    output logic             match
);
    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] mask_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q   <= '0;
            mask_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            key_q   <= ld_key;
            mask_q  <= ld_mask;
            valid_q <= ld_valid;
        end
    end

    // Compare against stored contents; a write in this cycle is not yet visible.
    always_comb begin
        match = valid_q && (((probe_key ^ key_q) & mask_q) == '0);
    end

    assign slot_valid = valid_q;

    // R2
    slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_q == $past(ld_valid)) && (key_q == $past(ld_key)) && (mask_q == $past(ld_mask)));

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(valid_q) && $stable(key_q) && $stable(mask_q));
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int N     = 10,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tcam_filter.sv
module tcam_filter #(
    parameter  int ENTRIES = 10,
    parameter  int KEY_W   = tcam_pkg::TUPLE_W,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [KEY_W-1:0]   wr_mask,
    input  logic               wr_valid,
    input  logic               lk_valid,
    input  logic [KEY_W-1:0]   lk_key,
    output logic               res_valid,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [ENTRIES-1:0] hit_map
);
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic               any_match;
    logic [IDX_W-1:0]   win_idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tcam_slot #(.KEY_W(KEY_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (wr_en && (wr_idx == IDX_W'(i))),
            .ld_key     (wr_key),
            .ld_mask    (wr_mask),
            .ld_valid   (wr_valid),
            .probe_key  (lk_key),
            .slot_valid (valid_vec[i]),
            .match      (match_vec[i])
        );
    end

    tcam_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .req (match_vec),
        .any (any_match),
        .idx (win_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            hit       <= 1'b0;
            hit_idx   <= '0;
            hit_map   <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                hit     <= any_match;
                hit_idx <= win_idx;
                hit_map <= match_vec;
            end else begin
                hit     <= 1'b0;
                hit_idx <= '0;
                hit_map <= '0;
            end
        end
    end

    // R6
    lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_map[hit_idx] &&
                ((hit_map & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));

    // R6
    miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_map == '0) && (hit_idx == '0));

    // R5
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid && !hit && (hit_map == '0));

    // R4
    invalid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ((hit_map & ~$past(valid_vec)) == '0));

    // R8
    bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) >= ENTRIES)) |=> $stable(valid_vec));
endmodule

// File: tb/test_tcam_filter.sv
module test_tcam_filter;
    localparam int N  = 10;
    localparam int KW = 104;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [KW-1:0] wr_key;
    logic [KW-1:0] wr_mask;
    logic          wr_valid;
    logic          lk_valid;
    logic [KW-1:0] lk_key;
    logic          res_valid;
    logic          hit;
    logic [IW-1:0] hit_idx;
    logic [N-1:0]  hit_map;

    int checks = 0;
    int errors = 0;

    logic [KW-1:0] m_key  [N];
    logic [KW-1:0] m_mask [N];
    bit            m_val  [N];

    always #10 clk = ~clk;

    tcam_filter i_tcam_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
        .wr_mask(wr_mask), .wr_valid(wr_valid), .lk_valid(lk_valid), .lk_key(lk_key),
        .res_valid(res_valid), .hit(hit), .hit_idx(hit_idx), .hit_map(hit_map)
    );

    function automatic logic [KW-1:0] mk(logic [31:0] s, logic [31:0] d,
                                         logic [15:0] sp, logic [15:0] dp, logic [7:0] pr);
        return {s, d, sp, dp, pr};
    endfunction

    function automatic logic [KW-1:0] rnd_key();
        logic [127:0] r = {$urandom, $urandom, $urandom, $urandom};
        return r[KW-1:0];
    endfunction

    function automatic logic [N-1:0] exp_map(logic [KW-1:0] k);
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++)
            m[i] = m_val[i] && (((k ^ m_key[i]) & m_mask[i]) == '0);
        return m;
    endfunction

    function automatic logic [IW-1:0] lowest(logic [N-1:0] m);
        logic [IW-1:0] r = '0;
        for (int i = N - 1; i >= 0; i--) if (m[i]) r = IW'(i);
        return r;
    endfunction

    task automatic check(string tag, logic ev, logic eh, logic [IW-1:0] ei, logic [N-1:0] em);
        checks++;
        if (res_valid !== ev || hit !== eh || hit_idx !== ei || hit_map !== em) begin
            errors++;
            $display("FAIL %s: actual v=%b hit=%b idx=%0d map=%b expected v=%b hit=%b idx=%0d map=%b",
                     tag, res_valid, hit, hit_idx, hit_map, ev, eh, ei, em);
        end
    endtask

    // Drive one cycle at a falling edge, then check the result at the next falling edge.
    task automatic step(string tag, bit we, int widx, logic [KW-1:0] wk, logic [KW-1:0] wm,
                        bit wv, bit lv, logic [KW-1:0] lk);
        logic [N-1:0] em;
        wr_en = we; wr_idx = IW'(widx); wr_key = wk; wr_mask = wm; wr_valid = wv;
        lk_valid = lv; lk_key = lk;
        em = lv ? exp_map(lk) : '0;           // old contents (R7)
        if (we && widx < N) begin
            m_key[widx] = wk; m_mask[widx] = wm; m_val[widx] = wv;
        end
        @(negedge clk);
        check(tag, lv, |em, lowest(em), em);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [KW-1:0] ka, kb, ones, k;
        void'($urandom(32'h5eed_1234));
        ones = '1;
        for (int i = 0; i < N; i++) begin m_key[i] = '0; m_mask[i] = '0; m_val[i] = 0; end
        rst_n = 1'b0; wr_en = 0; wr_idx = '0; wr_key = '0; wr_mask = '0; wr_valid = 0;
        lk_valid = 0; lk_key = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", 0, 0, '0, '0);

        ka = mk(32'h0a000001, 32'hc0a80102, 16'd1234, 16'd80, 8'd6);
        // R1 R4: empty table misses even an all-zero key
        step("R1 empty table", 0, 0, '0, '0, 0, 1, '0);
        step("R4 empty table random", 0, 0, '0, '0, 0, 1, rnd_key());
        // R7: write slot 3 and look up the same key in the same cycle
        step("R7 same-cycle write", 1, 3, ka, ones, 1, 1, ka);
        // R2: visible on the next cycle
        step("R2 write visible", 0, 0, '0, '0, 0, 1, ka);
        // R3: one cared bit differs
        step("R3 cared bit differs", 0, 0, '0, '0, 0, 1, ka ^ (104'd1 << 50));
        // R3: slot 7 ignores both ports (bits 39:8)
        kb = mk(32'h0a000002, 32'hc0a80103, 16'd0, 16'd0, 8'd17);
        step("R3 port wildcard write", 1, 7, kb, ones & ~(104'hFFFF_FFFF << 8), 1, 0, '0);
        step("R3 port wildcard hit", 0, 0, '0, '0, 0, 1,
             mk(32'h0a000002, 32'hc0a80103, 16'd5555, 16'd443, 8'd17));
        step("R3 proto still cared", 0, 0, '0, '0, 0, 1,
             mk(32'h0a000002, 32'hc0a80103, 16'd5555, 16'd443, 8'd6));
        // R6: slot 1 matches everything, so it wins over slot 3
        step("R6 wildcard write", 1, 1, '0, '0, 1, 0, '0);
        step("R6 lowest wins", 0, 0, '0, '0, 0, 1, ka);
        // R4: invalidate slot 1
        step("R4 invalidate", 1, 1, '0, '0, 0, 0, '0);
        step("R4 invalid ignored", 0, 0, '0, '0, 0, 1, ka);
        // R8: writes to slots 12 and 15 are dropped
        step("R8 bad index 12", 1, 12, '0, '0, 1, 0, '0);
        step("R8 bad index 15", 1, 15, '0, '0, 1, 0, '0);
        step("R8 no entry changed", 0, 0, '0, '0, 0, 1, rnd_key());
        step("R8 slot3 intact", 0, 0, '0, '0, 0, 1, ka);
        // R5: an idle cycle returns nothing
        step("R5 idle", 0, 0, '0, '0, 0, 0, ka);

        for (int n = 0; n < 400; n++) begin
            int sel = int'($urandom % N);
            if (($urandom % 4) == 0) begin
                k = rnd_key();
                step("R2 random write", 1, int'($urandom % 12), k,
                     (($urandom % 3) == 0) ? rnd_key() : ones, ($urandom % 5) != 0,
                     ($urandom % 2) == 1, m_key[sel]);
            end else begin
                k = (m_key[sel] & m_mask[sel]) | (rnd_key() & ~m_mask[sel]);
                if (($urandom % 3) == 0) k = k ^ (104'd1 << ($urandom % KW));
                step("R5 random lookup", 0, 0, '0, '0, 0, ($urandom % 8) != 0, k);
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule